// File: doc/BRIEF.md
# GF(2^191) Squaring and Trinomial Reduction Unit

This purely combinational unit produces a reduced element of GF(2^191) under the fixed modulus x^191 + x^9 + 1. It works in one of two modes. In square mode it squares the 191-bit input element. Each coefficient is moved to twice its index, so the squaring costs nothing but wires. In reduce mode it takes an externally supplied 381-bit polynomial product, such as the raw output of a field multiplier, and brings it back into the field.

Both modes share one reduction network. The upper 190 coefficients are folded into the lower 191 positions twice, once with no offset and once shifted up by 9. The eight coefficients that this shifted fold pushes past the top of the field are then folded a second time in the same two ways. The network contains only XOR gates. It has no iteration, no state and no clock, so a datapath can place it after a multiplier or in front of a register file write port.

Top module: `gf_sqr_red_unit`

## Requirements
- R1: In square mode (sq_mode_i = 1), an element whose bits 95 to 190 are all zero gives res_o with bit 2i equal to elem_i bit i, for i from 0 to 95.
- R2: In square mode, an element whose bits 95 to 190 are all zero gives res_o with every odd bit position at zero.
- R3: In reduce mode (sq_mode_i = 0), res_o equals prod_i modulo x^191 + x^9 + 1 for any 381-bit prod_i, where bit j of prod_i is the coefficient of x^j.
- R4: In reduce mode, a prod_i with bits 191 to 380 all zero appears unchanged on res_o as prod_i bits 0 to 190.
- R5: In reduce mode, prod_i holding only x^191 gives res_o with only bits 0 and 9 set.
- R6: In reduce mode, prod_i holding only x^380 gives res_o with only bits 7, 16 and 189 set, because of the second fold.
- R7: In square mode, res_o does not depend on prod_i. In reduce mode, res_o does not depend on elem_i.
- R8: res_o follows its inputs within the same time step, with no clock edge involved.
- R9: The result in square mode equals the carry-less product of elem_i with itself, reduced by the trinomial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sq_mode_i | input | 1 | 1: square elem_i; 0: reduce prod_i |
| prod_i | input | 381 | Unreduced polynomial product, bit j is the coefficient of x^j |
| elem_i | input | 191 | Field element to square |
| res_o | output | 191 | Reduced field element |

## Verification
The bound checker tests every input change against four rules.
- A product with no high coefficients passes through unchanged.
- The lone x^191 term maps to 1 + x^9.
- Squaring a small element in square mode spreads its bits onto the even positions.
- The odd positions of that square stay at zero.

Full reduction needs a reference model, so the bench shows it. The bench does long division by the trinomial and compares the result for dense and sparse products, including the double-overflow term x^380. The bench also checks that squaring matches a carry-less self-multiplication. It shows that the unselected operand has no effect by changing that operand and checking that the output holds.

// File: rtl/gf191_pkg.sv
package gf191_pkg;
  localparam int unsigned FIELD_M = 191;
  localparam int unsigned TAP_N   = 9;
endpackage

// File: rtl/gf_sq_spread.sv
module gf_sq_spread #(
  parameter int unsigned M = gf191_pkg::FIELD_M
) (
  input  logic [M-1:0]   elem_i,
  output logic [2*M-2:0] spread_o
);
  for (genvar i = 0; i < M; i++) begin : g_even
    assign spread_o[2*i] = elem_i[i];
  end
  for (genvar i = 0; i < M-1; i++) begin : g_odd
    assign spread_o[2*i+1] = 1'b0;
  end
endmodule

// File: rtl/gf_tri_fold.sv
module gf_tri_fold #(
  parameter int unsigned M = gf191_pkg::FIELD_M,
  parameter int unsigned N = gf191_pkg::TAP_N
) (
  input  logic [2*M-2:0] poly_i,
  output logic [M-1:0]   red_o
);
  localparam int unsigned HW = M - 1;   // high part width
  localparam int unsigned OW = N - 1;   // overflow of the offset-N fold

  logic [M-1:0]  lo_w;
  logic [HW-1:0] hi_w;
  logic [OW-1:0] ovf_w;
  logic [M-1:0]  hi_at0_w, hi_atn_w, ovf_at0_w, ovf_atn_w, pass1_w;

  assign lo_w  = poly_i[M-1:0];
  assign hi_w  = poly_i[2*M-2:M];
  assign ovf_w = hi_w[HW-1:M-N];

  assign hi_at0_w  = {1'b0, hi_w};
  assign hi_atn_w  = {hi_w[M-N-1:0], {N{1'b0}}};
  assign ovf_at0_w = {{(M-OW){1'b0}}, ovf_w};
  assign ovf_atn_w = {{(M-OW-N){1'b0}}, ovf_w, {N{1'b0}}};

  assign pass1_w = lo_w ^ hi_at0_w ^ hi_atn_w;
  assign red_o   = pass1_w ^ ovf_at0_w ^ ovf_atn_w;
endmodule

// File: rtl/gf_sqr_red_unit.sv
module gf_sqr_red_unit #(
  parameter int unsigned M = gf191_pkg::FIELD_M,
  parameter int unsigned N = gf191_pkg::TAP_N
) (
  input  logic           sq_mode_i,
  input  logic [2*M-2:0] prod_i,
  input  logic [M-1:0]   elem_i,
  output logic [M-1:0]   res_o
);
  localparam int unsigned W = 2*M - 1;

  logic [W-1:0] spread_w, fold_in_w;

  gf_sq_spread #(.M(M)) u_spread (
    .elem_i   (elem_i),
    .spread_o (spread_w)
  );

  assign fold_in_w = sq_mode_i ? spread_w : prod_i;

  gf_tri_fold #(.M(M), .N(N)) u_fold (
    .poly_i (fold_in_w),
    .red_o  (res_o)
  );
endmodule

// File: rtl/gf_sqr_red_chk.sv
module gf_sqr_red_chk #(
  parameter int unsigned M = gf191_pkg::FIELD_M,
  parameter int unsigned N = gf191_pkg::TAP_N
) (
  input logic           sq_mode_i,
  input logic [2*M-2:0] prod_i,
  input logic [M-1:0]   elem_i,
  input logic [M-1:0]   res_o
);
  localparam int unsigned H = (M + 1) / 2;

  function automatic logic [H-1:0] evens(input logic [M-1:0] v);
    logic [H-1:0] r;
    for (int i = 0; i < H; i++) r[i] = v[2*i];
    return r;
  endfunction

  function automatic logic [M-1:0] odd_mask();
    logic [M-1:0] r;
    for (int i = 0; i < M; i++) r[i] = (i % 2) == 1;
    return r;
  endfunction

  logic small_sq;
  assign small_sq = sq_mode_i && (elem_i[M-1:H-1] == '0);

  always_comb begin
    p_pass_low_r4: assert (sq_mode_i || prod_i[2*M-2:M] != '0 || res_o == prod_i[M-1:0])
      else $error("R4 low product not passed through");
    p_top_term_r5: assert (sq_mode_i || prod_i != ((2*M-1)'(1) << M) ||
                           res_o == ((M'(1) << N) | M'(1)))
      else $error("R5 x^M not mapped to 1 + x^N");
    p_even_spread_r1: assert (!small_sq || evens(res_o)[H-2:0] == elem_i[H-2:0])
      else $error("R1 square bits misplaced");
    p_odd_zero_r2: assert (!small_sq || (res_o & odd_mask()) == '0)
      else $error("R2 odd bit set in square");
  end
endmodule

bind gf_sqr_red_unit gf_sqr_red_chk #(.M(M), .N(N)) u_chk (
  .sq_mode_i (sq_mode_i),
  .prod_i    (prod_i),
  .elem_i    (elem_i),
  .res_o     (res_o)
);

// File: tb/gf_sqr_red_unit_tb.sv
module gf_sqr_red_unit_tb;
  localparam int unsigned M  = 191;
  localparam int unsigned N  = 9;
  localparam int unsigned W  = 2*M - 1;
  localparam int          NV = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         sq_mode;
  logic [W-1:0] prod;
  logic [M-1:0] elem;
  logic [M-1:0] res;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  gf_sqr_red_unit u_dut (
    .sq_mode_i (sq_mode),
    .prod_i    (prod),
    .elem_i    (elem),
    .res_o     (res)
  );

  localparam logic         MODE_T [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [W-1:0] PROD_T [NV] = '{
    {W{1'b1}},
    W'({191{2'b10}}),
    {{(W-M){1'b1}}, {M{1'b0}}},
    (W'(1) << (W-1)) | (W'(1) << M) | W'(5),
    {W{1'b1}}, '0, W'({191{2'b01}}), {W{1'b1}}};
  localparam logic [M-1:0] ELEM_T [NV] = '{
    '0, '0, '0, '0,
    {M{1'b1}}, M'(1) << (M-1), M'({96{2'b10}}), M'(191'h5a5a_c3c3_0ff0_1234_dead_beef)};

  function automatic logic [M-1:0] ref_mod(input logic [W-1:0] c);
    logic [W-1:0] t = c;
    for (int i = W-1; i >= int'(M); i--) begin
      if (t[i]) begin
        t[i] = 1'b0;
        t[i-M+N] = t[i-M+N] ^ 1'b1;
        t[i-M] = t[i-M] ^ 1'b1;
      end
    end
    return t[M-1:0];
  endfunction

  function automatic logic [W-1:0] clmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [W-1:0] r = '0;
    for (int i = 0; i < int'(M); i++)
      if (a[i]) r = r ^ (W'(b) << i);
    return r;
  endfunction

  task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [W-1:0] p, input logic [M-1:0] e);
    @(negedge clk);
    sq_mode = m; prod = p; elem = e;
    #1;
  endtask

  initial begin
    logic [M-1:0] first_res;
    logic [M-1:0] spread_exp;
    logic [W-1:0] lfsr_p;
    sq_mode = 1'b0; prod = '0; elem = '0;
    #1;
    check("R4 zero inputs give zero", res, '0);

    for (int v = 0; v < NV; v++) begin
      apply(MODE_T[v], PROD_T[v], ELEM_T[v]);
      if (MODE_T[v]) check("R9 square equals self product", res, ref_mod(clmul(ELEM_T[v], ELEM_T[v])));
      else           check("R3 reduction vs long division", res, ref_mod(PROD_T[v]));
    end

    apply(1'b0, W'(1) << M, '0);
    check("R5 x^191 term", res, (M'(1) << N) | M'(1));
    apply(1'b0, W'(1) << (W-1), '0);
    check("R6 x^380 double fold", res, (M'(1) << 189) | (M'(1) << 16) | (M'(1) << 7));
    apply(1'b0, {{(W-M){1'b0}}, M'(191'h7fff_0123_4567_89ab_cdef)}, '0);
    check("R4 low-only product unchanged", res, M'(191'h7fff_0123_4567_89ab_cdef));

    apply(1'b1, '0, M'(96'hf00d_1357_9bdf_2468_ace0_beef) & {{96{1'b0}}, {95{1'b1}}});
    spread_exp = '0;
    for (int i = 0; i < 95; i++) spread_exp[2*i] = elem[i];
    check("R1 R2 small square spread", res, spread_exp);

    apply(1'b1, '0, M'(191'h1234_5678_9abc_def0_1357));
    first_res = res;
    apply(1'b1, {W{1'b1}}, M'(191'h1234_5678_9abc_def0_1357));
    check("R7 prod ignored in square mode", res, first_res);
    apply(1'b0, W'(381'hbeef_cafe_0000_1111_2222), '0);
    first_res = res;
    apply(1'b0, W'(381'hbeef_cafe_0000_1111_2222), {M{1'b1}});
    check("R7 elem ignored in reduce mode", res, first_res);

    @(negedge clk);
    sq_mode = 1'b0; prod = W'(1) << M; elem = '0;
    #0.1;
    check("R8 same time step response", res, (M'(1) << N) | M'(1));

    lfsr_p = {W{1'b1}} ^ (W'(1) << 77);
    for (int k = 0; k < 12; k++) begin
      lfsr_p = {lfsr_p[W-2:0], lfsr_p[W-1] ^ lfsr_p[W-3] ^ lfsr_p[100]};
      lfsr_p = lfsr_p ^ (lfsr_p << 13);
      apply(1'b0, lfsr_p, lfsr_p[M-1:0]);
      check("R3 pseudo-random reduction", res, ref_mod(lfsr_p));
      apply(1'b1, lfsr_p, lfsr_p[W-1:W-M]);
      check("R9 pseudo-random square", res, ref_mod(clmul(lfsr_p[W-1:W-M], lfsr_p[W-1:W-M])));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule